// File: doc/BRIEF.md
# Flag-Producing Function-Coded ALU

This block is a purely combinational arithmetic and logic unit for a datapath of parameterised width (32 bits by default). A packed five-bit function code selects one of four result paths: an adder/subtractor, a comparison that reads the subtractor's flags, a bidirectional shifter that moves operand B by an amount taken from operand A, and a bitwise logic unit. Alongside the result the block reports negative, overflow, carry and zero flags, so a branch unit or a condition register next to it can consume them in the same cycle.

The comparisons add no comparator of their own. Signed less-than is read from the sign and overflow of the difference, and unsigned less-than from the borrow of that same difference. The shifter is a single right-shifting structure that handles left shifts by reversing the bit order before and after the shift. A parameter chooses between an explicit log-stage barrel and an operator-based description.

Top module: `flag_alu`

## Requirements
- R1: The function code `fn` is decoded as fn[4] = subtract, fn[3:2] = selector, fn[1] = shift path, fn[0] = math path. All 32 code values produce a defined result.
- R2: With math=1 and shift=0, the result is A+B when fn[4]=0 and A-B when fn[4]=1, modulo 2^WIDTH.
- R3: With math=1, shift=1 and fn[2]=0, the result is 1 when A is less than B as two's-complement numbers and 0 otherwise. The value is zero-extended to WIDTH bits.
- R4: With math=1, shift=1 and fn[2]=1, the result is 1 when A is less than B as unsigned numbers and 0 otherwise. This is the borrow of A-B, meaning no carry out of A + ~B + 1.
- R5: A comparison code always subtracts. Its result and flags do not depend on fn[4].
- R6: With math=0 and shift=1, B is shifted by A[4:0]; higher bits of A and fn[4] have no effect. Selector 00 and 01 give a left shift, 10 a logical right shift and 11 an arithmetic right shift.
- R7: With math=0 and shift=0, the selector picks AND (00), OR (01), XOR (10) or OR (11).
- R8: For every code, `c_flag` is the carry out of A + (B or ~B) + s, `n_flag` is the top bit of that sum, and `v_flag` is its signed overflow. Here s = 1 when fn[4]=1 or the code is a comparison, and s = 0 otherwise.
- R9: `z_flag` is 1 exactly when every bit of `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn | input | 5 | Packed function code |
| a | input | WIDTH | Operand A; also supplies the shift amount |
| b | input | WIDTH | Operand B; the value shifted on shift codes |
| result | output | WIDTH | Selected result |
| n_flag | output | 1 | Sign of the adder output |
| v_flag | output | 1 | Signed overflow of the adder |
| c_flag | output | 1 | Carry out of the adder |
| z_flag | output | 1 | Result is all zeros |

## Verification
The hardest situation to reach is a signed comparison in which the subtraction overflows. In that case the sign of the difference alone gives the wrong answer, and only the overflow correction makes it right. It needs operands of opposite sign near the extremes, such as the most negative value against 1, which uniform random data seldom produces. The stimulus therefore places these operand pairs explicitly. It also covers shift amounts with bits set above bit 4, comparison codes with fn[4] cleared, and a pseudo-random sweep over every one of the 32 codes.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int FN_W = 5;

   typedef struct packed {
      logic       sub;
      logic [1:0] sel;
      logic       shft;
      logic       math;
   } alu_fn_t;

   typedef enum logic [1:0] {
      PATH_LOGIC = 2'b00,
      PATH_ARITH = 2'b01,
      PATH_SHIFT = 2'b10,
      PATH_CMP   = 2'b11
   } alu_path_e;

   function automatic alu_path_e path_of(input alu_fn_t f);
      return alu_path_e'({f.shft, f.math});
   endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             subtract,
   output logic [WIDTH-1:0] sum,
   output logic             carry,
   output logic             ovf
);
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   wide;

   always_comb begin
      b_eff = subtract ? ~b : b;
      wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
      sum   = wide[WIDTH-1:0];
      carry = wide[WIDTH];
      ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int WIDTH  = 32,
   parameter bit BARREL = 1'b1,
   localparam int SW    = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [SW-1:0]    amt,
   input  logic             left,
   input  logic             arith,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] rin;
   logic [WIDTH-1:0] rout;
   logic             fill;

   always_comb begin
      fill = arith & ~left & din[WIDTH-1];
      for (int i = 0; i < WIDTH; i++) begin
         rin[i] = left ? din[WIDTH-1-i] : din[i];
      end
   end

   generate
      if (BARREL) begin : g_barrel
         logic [WIDTH-1:0] stage [0:SW];
         assign stage[0] = rin;
         for (genvar k = 0; k < SW; k++) begin : g_stage
            localparam int D = 1 << k;
            assign stage[k+1] = amt[k] ? {{D{fill}}, stage[k][WIDTH-1:D]} : stage[k];
         end
         assign rout = stage[SW];
      end else begin : g_operator
         logic signed [WIDTH:0] ext;
         logic signed [WIDTH:0] shifted;
         always_comb begin
            ext     = {fill, rin};
            shifted = ext >>> amt;
            rout    = shifted[WIDTH-1:0];
         end
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
         dout[i] = left ? rout[WIDTH-1-i] : rout[i];
      end
   end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       sel,
   output logic [WIDTH-1:0] y
);
   always_comb begin
      unique case (sel)
         2'b00:   y = a & b;
         2'b10:   y = a ^ b;
         default: y = a | b;
      endcase
   end
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
   parameter int WIDTH  = 32,
   parameter bit BARREL = 1'b1
) (
   input  logic [4:0]       fn,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] result,
   output logic             n_flag,
   output logic             v_flag,
   output logic             c_flag,
   output logic             z_flag
);
   import alu_pkg::*;

   localparam int SW = $clog2(WIDTH);

   generate
      if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("flag_alu: WIDTH must be a power of two of at least 2");
      end
   endgenerate

   alu_fn_t          f;
   alu_path_e        path;
   logic             do_sub;
   logic [WIDTH-1:0] sum, shv, lgv;
   logic             carry, ovf, less;

   always_comb begin
      f      = alu_fn_t'(fn);
      path   = path_of(f);
      do_sub = f.sub | (path == PATH_CMP);
   end

   alu_addsub #(.WIDTH(WIDTH)) u_add (
      .a(a), .b(b), .subtract(do_sub),
      .sum(sum), .carry(carry), .ovf(ovf)
   );

   alu_shifter #(.WIDTH(WIDTH), .BARREL(BARREL)) u_shf (
      .din(b), .amt(a[SW-1:0]), .left(~f.sel[1]), .arith(f.sel[0]),
      .dout(shv)
   );

   alu_logic #(.WIDTH(WIDTH)) u_lgc (
      .a(a), .b(b), .sel(f.sel), .y(lgv)
   );

   always_comb begin
      less = f.sel[0] ? ~carry : (sum[WIDTH-1] ^ ovf);
      unique case (path)
         PATH_ARITH: result = sum;
         PATH_CMP:   result = {{(WIDTH-1){1'b0}}, less};
         PATH_SHIFT: result = shv;
         default:    result = lgv;
      endcase
      n_flag = sum[WIDTH-1];
      v_flag = ovf;
      c_flag = carry;
      z_flag = ~|result;
   end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic [4:0]       fn,
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic [WIDTH-1:0] result,
   input logic             c_flag,
   input logic             z_flag
);
   localparam int SW = $clog2(WIDTH);

   always_comb begin
      if (fn[0] && !fn[1] && !fn[4])
         assert_sum_R2: assert (result == a + b);
      if (fn[0] && fn[1] && !fn[2])
         assert_slt_R3: assert (result == {{(WIDTH-1){1'b0}}, $signed(a) < $signed(b)});
      if (fn[0] && fn[1] && fn[2])
         assert_sltu_R4: assert (result == {{(WIDTH-1){1'b0}}, a < b});
      if (fn[0] && fn[1])
         assert_cmp_sub_R5: assert (c_flag == (a >= b));
      if (!fn[0] && fn[1] && !fn[3])
         assert_shl_R6: assert (result == (b << a[SW-1:0]));
      if (fn[4] && !fn[1] && fn[0])
         assert_zero_R9: assert (z_flag == (a == b));
   end
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .fn(fn), .a(a), .b(b), .result(result), .c_flag(c_flag), .z_flag(z_flag)
);

// File: tb/flag_alu_tb.sv
module flag_alu_tb;
   localparam int  W      = 32;
   localparam time PERIOD = 10ns;

   typedef struct {
      logic [W-1:0] res;
      logic         n, v, c, z;
      string        tag;
      logic [4:0]   fn;
      logic [W-1:0] a, b;
   } exp_t;

   logic         clk = 1'b0;
   logic [4:0]   fn  = '0;
   logic [W-1:0] a   = '0;
   logic [W-1:0] b   = '0;
   logic [W-1:0] result;
   logic         n_flag, v_flag, c_flag, z_flag;
   int           n_run = 0, n_fail = 0;
   bit           done = 1'b0;
   exp_t         q[$];
   logic [31:0]  lfsr = 32'hACE1_2345;

   always #(PERIOD/2) clk = ~clk;

   flag_alu #(.WIDTH(W)) u_dut (
      .fn(fn), .a(a), .b(b), .result(result),
      .n_flag(n_flag), .v_flag(v_flag), .c_flag(c_flag), .z_flag(z_flag)
   );

   function automatic exp_t model(input logic [4:0] f, input logic [W-1:0] x, input logic [W-1:0] y);
      exp_t e;
      logic s;
      logic [W-1:0] yb;
      logic [W:0] w;
      s  = f[4] | (f[0] & f[1]);
      yb = s ? ~y : y;
      w  = {1'b0, x} + {1'b0, yb} + (W+1)'(s);
      e.n = w[W-1];
      e.c = w[W];
      e.v = (x[W-1] == yb[W-1]) && (w[W-1] != x[W-1]);
      case ({f[1], f[0]})
         2'b01: begin e.res = f[4] ? x - y : x + y; e.tag = "R2"; end
         2'b11: begin
            e.res = f[2] ? W'(x < y) : W'($signed(x) < $signed(y));
            e.tag = f[2] ? "R4" : "R3";
         end
         2'b10: begin
            if (!f[3])     e.res = y << x[4:0];
            else if (!f[2]) e.res = y >> x[4:0];
            else           e.res = W'($signed(y) >>> x[4:0]);
            e.tag = "R6";
         end
         default: begin
            case (f[3:2])
               2'b00:   e.res = x & y;
               2'b10:   e.res = x ^ y;
               default: e.res = x | y;
            endcase
            e.tag = "R7";
         end
      endcase
      e.z = (e.res == '0);
      e.fn = f; e.a = x; e.b = y;
      return e;
   endfunction

   task automatic drive(input logic [4:0] f, input logic [W-1:0] x, input logic [W-1:0] y,
                        input string extra = "");
      exp_t e;
      @(posedge clk);
      #1;
      fn = f; a = x; b = y;
      e = model(f, x, y);
      if (extra != "") e.tag = {e.tag, "/", extra};
      q.push_back(e);
   endtask

   task automatic check(input bit ok, input string tag, input exp_t e,
                        input logic [W-1:0] act, input logic [W-1:0] expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s fn=%b a=%h b=%h actual=%h expected=%h", tag, e.fn, e.a, e.b, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(result === e.res, e.tag, e, result, e.res);
         check({n_flag, v_flag, c_flag} === {e.n, e.v, e.c}, "R8", e,
               W'({n_flag, v_flag, c_flag}), W'({e.n, e.v, e.c}));
         check(z_flag === e.z, "R9", e, W'(z_flag), W'(e.z));
      end
   end

   function automatic logic [31:0] step(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   initial begin
      // R1 / R2: plain add, add with signed overflow, subtract to zero
      drive(5'b00001, 32'd5, 32'd7);
      drive(5'b00001, 32'h7FFF_FFFF, 32'd1, "R8");
      drive(5'b10001, 32'h1234_5678, 32'h1234_5678, "R9");
      // R3: signed compare, including the overflowing case
      drive(5'b10011, 32'hFFFF_FFFF, 32'd1);
      drive(5'b10011, 32'h8000_0000, 32'd1);
      drive(5'b10011, 32'h7FFF_FFFF, 32'h8000_0000);
      // R4: unsigned compare as borrow
      drive(5'b10111, 32'hFFFF_FFFF, 32'd1);
      drive(5'b10111, 32'd0, 32'd1);
      drive(5'b10111, 32'd9, 32'd9);
      // R5: comparison with fn[4] cleared still subtracts
      drive(5'b00011, 32'h8000_0000, 32'd1, "R5");
      drive(5'b00111, 32'd3, 32'd4, "R5");
      // R6: shift amount upper bits and fn[4] ignored; selector 01 is left
      drive(5'b00010, 32'h0000_0021, 32'h0000_0003);
      drive(5'b10010, 32'hFFFF_FFE4, 32'h0000_0001);
      drive(5'b00110, 32'd4, 32'h0000_00F0);
      drive(5'b01010, 32'd31, 32'h8000_0000);
      drive(5'b01110, 32'd31, 32'h8000_0000);
      drive(5'b01110, 32'd0, 32'hC000_0001);
      // R7: selector 11 behaves as OR
      drive(5'b01100, 32'hF0F0_0000, 32'h0F0F_00FF);
      drive(5'b00000, 32'hF0F0_0000, 32'h0F0F_00FF, "R9");
      // R1: sweep over every function code
      for (int k = 0; k < 40; k++) begin
         for (int c = 0; c < 32; c++) begin
            logic [W-1:0] x, y;
            lfsr = step(lfsr); x = lfsr;
            lfsr = step(lfsr); y = lfsr;
            if (k % 4 == 1) y = x;
            if (k % 4 == 2) x = {x[31], 31'h0};
            drive(5'(c), x, y, "R1");
         end
      end
      @(posedge clk);
      @(negedge clk);
      @(posedge clk);
      if (q.size() != 0) begin
         n_run++; n_fail++;
         $display("FAIL R1 scoreboard left %0d items, actual=%0d expected=0", q.size(), q.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL R1 watchdog expired, actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule